// File: doc/BRIEF.md
# Single-Accumulator Fetch-Execute Core

This block is a small stored-program processor built around one accumulator. It takes every instruction and every operand from one shared read/write memory. Each instruction word is 16 bits wide. Its upper four bits select the operation and its lower twelve bits give a direct word address. The core supports five operations: load the accumulator, add to it, store it back, jump unconditionally, and stop.

Every memory transfer goes through an internal address register and an internal buffer register. The program counter and the accumulator never drive the memory directly. The memory is synchronous, single-ported and returns read data one cycle after it sees the address. A sequencer runs one fetch phase and then one execute phase per instruction, and it inserts a wait state after each read address it issues.

The core is used by preloading memory with a program while reset is held. Reset is then released, and the program runs until the core reports that it has stopped. The accumulator and the program counter are visible at the ports, and the memory holds the results.

Top module: `acc_core`

## Requirements
- R1: While reset is asserted and right after it, the program counter reads the start address (default 0x300), the accumulator reads zero, the stopped flag is low and no memory write is issued. Reset asserts asynchronously, and the core leaves reset two rising clock edges after the reset input rises.
- R2: A fetch reads the word at the program-counter address into the instruction register and then advances the program counter by one. Bits [15:12] of the word are the operation code and bits [11:0] are the operand address.
- R3: Operation code 0001 loads the accumulator with the memory word at the operand address.
- R4: Operation code 0010 writes the accumulator to the operand address as a write pulse lasting one cycle. Memory holds no other changes.
- R5: Operation code 0101 adds the memory word at the operand address to the accumulator as 16-bit two's complement. The sum wraps on overflow and no flag is raised.
- R6: Operation code 1000 replaces the program counter with the operand address, so the next fetch is taken from that target.
- R7: Operation code 0000 raises the stopped output. From then on it stays high until reset, the program counter and accumulator hold, and no memory write occurs.
- R8: Every other operation code leaves the accumulator and memory unchanged and continues with the next sequential instruction.
- R9: The program counter is 12 bits wide and advances from 0xFFF to 0x000.
- R10: Counted in rising clock edges, a fetch plus decode takes 5 edges. Load and add take 3 more edges, store takes 1 more, and jump, stop and the no-op codes take none. The stopped output rises 2 + the sum of these costs edges after the reset input rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mem_addr | output | 12 | Word address to memory, taken from the address register |
| mem_wdata | output | 16 | Write data to memory, taken from the buffer register |
| mem_we | output | 1 | Write strobe, lasts one cycle per store |
| mem_rdata | input | 16 | Read data, valid one cycle after the address |
| acc_value | output | 16 | Current accumulator |
| pc_value | output | 12 | Current program counter |
| halted | output | 1 | High once a stop instruction has executed |

## Verification
A sequencer stuck in a wrong state, or one that skips the read wait state, shows up at the stop output. The stop edge arrives on a different cycle from the one predicted by the per-instruction cycle costs, so the timing check catches it within the run of a single program. A wrongly loaded instruction or buffer register corrupts the accumulator or memory image on the next load, add or store, and the end-of-run comparison reports it. A wrong program-counter update sends the fetch to the wrong word, and that changes the final program counter and the edge count of the run. Random programs with forward jumps, together with directed wrap-around cases, expose these faults within a few hundred cycles.

// File: rtl/acc_pkg.sv
package acc_pkg;

  localparam int OPC_W = 4;

  typedef enum logic [OPC_W-1:0] {
    OP_HALT  = 4'b0000,
    OP_LOAD  = 4'b0001,
    OP_STORE = 4'b0010,
    OP_ADD   = 4'b0101,
    OP_JUMP  = 4'b1000
  } opcode_e;

  typedef enum logic [3:0] {
    ST_FETCH_ADDR = 4'd0,
    ST_FETCH_WAIT = 4'd1,
    ST_FETCH_CAPT = 4'd2,
    ST_FETCH_IR   = 4'd3,
    ST_DECODE     = 4'd4,
    ST_OPND_WAIT  = 4'd5,
    ST_OPND_CAPT  = 4'd6,
    ST_EXEC       = 4'd7,
    ST_WRITE      = 4'd8,
    ST_HALT       = 4'd9
  } seq_state_e;

  typedef struct packed {
    logic mar_from_pc;
    logic mar_from_ir;
    logic mbr_from_mem;
    logic mbr_from_acc;
    logic ir_load;
    logic pc_incr;
    logic pc_jump;
    logic acc_from_mem;
    logic acc_from_sum;
  } dp_ctrl_t;

endpackage

// File: rtl/acc_rst_sync.sv
module acc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  generate
    genvar g;
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[g] <= 1'b0;
          else        sync_q[g] <= 1'b1;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[g] <= 1'b0;
          else        sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/acc_adder.sv
module acc_adder #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum
);

  // two's complement, carry out discarded
  always_comb begin
    sum = a + b;
  end

endmodule

// File: rtl/acc_seq.sv
module acc_seq
  import acc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [OPC_W-1:0]     opcode,
  output seq_state_e           state,
  output dp_ctrl_t             ctrl,
  output logic                 mem_write,
  output logic                 halted
);

  seq_state_e st_q, st_d;

  always_comb begin
    st_d      = st_q;
    ctrl      = '0;
    mem_write = 1'b0;
    halted    = 1'b0;
    case (st_q)
      ST_FETCH_ADDR: begin
        ctrl.mar_from_pc = 1'b1;
        st_d             = ST_FETCH_WAIT;
      end
      ST_FETCH_WAIT: begin
        st_d = ST_FETCH_CAPT;
      end
      ST_FETCH_CAPT: begin
        ctrl.mbr_from_mem = 1'b1;
        st_d              = ST_FETCH_IR;
      end
      ST_FETCH_IR: begin
        ctrl.ir_load = 1'b1;
        ctrl.pc_incr = 1'b1;
        st_d         = ST_DECODE;
      end
      ST_DECODE: begin
        case (opcode)
          OP_LOAD, OP_ADD: begin
            ctrl.mar_from_ir = 1'b1;
            st_d             = ST_OPND_WAIT;
          end
          OP_STORE: begin
            ctrl.mar_from_ir  = 1'b1;
            ctrl.mbr_from_acc = 1'b1;
            st_d              = ST_WRITE;
          end
          OP_JUMP: begin
            ctrl.pc_jump = 1'b1;
            st_d         = ST_FETCH_ADDR;
          end
          OP_HALT: begin
            st_d = ST_HALT;
          end
          default: begin
            st_d = ST_FETCH_ADDR;
          end
        endcase
      end
      ST_OPND_WAIT: begin
        st_d = ST_OPND_CAPT;
      end
      ST_OPND_CAPT: begin
        ctrl.mbr_from_mem = 1'b1;
        st_d              = ST_EXEC;
      end
      ST_EXEC: begin
        if (opcode == OP_ADD) ctrl.acc_from_sum = 1'b1;
        else                  ctrl.acc_from_mem = 1'b1;
        st_d = ST_FETCH_ADDR;
      end
      ST_WRITE: begin
        mem_write = 1'b1;
        st_d      = ST_FETCH_ADDR;
      end
      ST_HALT: begin
        halted = 1'b1;
        st_d   = ST_HALT;
      end
      default: begin
        st_d = ST_FETCH_ADDR;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_FETCH_ADDR;
    else        st_q <= st_d;
  end

  assign state = st_q;

endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
  import acc_pkg::*;
#(
  parameter int                ADDR_W     = 12,
  parameter int                DATA_W     = 16,
  parameter logic [ADDR_W-1:0] START_ADDR = 12'h300
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dp_ctrl_t          ctrl,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] pc_q,
  output logic [DATA_W-1:0] ir_q,
  output logic [ADDR_W-1:0] mar_q,
  output logic [DATA_W-1:0] mbr_q,
  output logic [DATA_W-1:0] acc_q
);

  logic [ADDR_W-1:0] pc_d, mar_d;
  logic [DATA_W-1:0] ir_d, mbr_d, acc_d, sum;
  logic              pc_en, mar_en, mbr_en, ir_en, acc_en;

  acc_adder #(.W(DATA_W)) u_adder (
    .a   (acc_q),
    .b   (mbr_q),
    .sum (sum)
  );

  // next-state selection and clock enables
  always_comb begin
    pc_en  = ctrl.pc_incr | ctrl.pc_jump;
    pc_d   = ctrl.pc_jump ? ir_q[ADDR_W-1:0] : pc_q + 1'b1;

    mar_en = ctrl.mar_from_pc | ctrl.mar_from_ir;
    mar_d  = ctrl.mar_from_ir ? ir_q[ADDR_W-1:0] : pc_q;

    mbr_en = ctrl.mbr_from_mem | ctrl.mbr_from_acc;
    mbr_d  = ctrl.mbr_from_acc ? acc_q : mem_rdata;

    ir_en  = ctrl.ir_load;
    ir_d   = mbr_q;

    acc_en = ctrl.acc_from_mem | ctrl.acc_from_sum;
    acc_d  = ctrl.acc_from_sum ? sum : mbr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_q <= START_ADDR;
    else if (pc_en) pc_q <= pc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mar_q <= '0;
    else if (mar_en) mar_q <= mar_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mbr_q <= '0;
    else if (mbr_en) mbr_q <= mbr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ir_q <= '0;
    else if (ir_en) ir_q <= ir_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end

endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_pkg::*;
#(
  parameter int                ADDR_W      = 12,
  parameter int                DATA_W      = 16,
  parameter logic [ADDR_W-1:0] START_ADDR  = 12'h300,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] acc_value,
  output logic [ADDR_W-1:0] pc_value,
  output logic              halted
);

  // opcode field sits above the address field and must be OPC_W bits
  localparam int OP_W = DATA_W - ADDR_W;

  logic              core_rst_n;
  seq_state_e        seq_st;
  dp_ctrl_t          ctrl;
  logic [ADDR_W-1:0] pc_q, mar_q;
  logic [DATA_W-1:0] ir_q, mbr_q, acc_q;

  acc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (core_rst_n)
  );

  acc_seq u_seq (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .opcode    (ir_q[DATA_W-1 -: OP_W]),
    .state     (seq_st),
    .ctrl      (ctrl),
    .mem_write (mem_we),
    .halted    (halted)
  );

  acc_datapath #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .START_ADDR (START_ADDR)
  ) u_dp (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .ctrl      (ctrl),
    .mem_rdata (mem_rdata),
    .pc_q      (pc_q),
    .ir_q      (ir_q),
    .mar_q     (mar_q),
    .mbr_q     (mbr_q),
    .acc_q     (acc_q)
  );

  assign mem_addr  = mar_q;
  assign mem_wdata = mbr_q;
  assign acc_value = acc_q;
  assign pc_value  = pc_q;

endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk
  import acc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input seq_state_e        st,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_we,
  input logic [DATA_W-1:0] acc_value,
  input logic [ADDR_W-1:0] pc_value,
  input logic              halted
);

  // R7
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  // R7
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_we);

  // R4
  store_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_wdata == acc_value));

  // R4
  store_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  // R2
  fetch_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FETCH_WAIT) |-> (mem_addr == pc_value));

  // R9
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FETCH_IR) |=> (pc_value == ADDR_W'($past(pc_value) + 1'b1)));

  // R8
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_EXEC) |=> $stable(acc_value));

endmodule

bind acc_core acc_core_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .st        (seq_st),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_we    (mem_we),
  .acc_value (acc_value),
  .pc_value  (pc_value),
  .halted    (halted)
);

// File: tb/test_acc_core.sv
`timescale 1ns/1ps
module test_acc_core;

  logic        clk;
  logic        rst_n;
  logic [11:0] mem_addr;
  logic [15:0] mem_wdata;
  logic        mem_we;
  logic [15:0] mem_rdata;
  logic [15:0] acc_value;
  logic [11:0] pc_value;
  logic        halted;

  int checks;
  int failures;
  int wr_after_halt;

  logic [15:0] mem     [4096];
  logic [15:0] ref_mem [4096];

  acc_core i_acc_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .mem_rdata (mem_rdata),
    .acc_value (acc_value),
    .pc_value  (pc_value),
    .halted    (halted)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // synchronous memory, one cycle read latency
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  always @(posedge clk) begin
    if (halted && mem_we) wr_after_halt++;
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // instruction-level model of the requirements
  function automatic void ref_run(input logic [11:0] start,
                                  output logic [15:0] acc,
                                  output logic [11:0] pc,
                                  output int cyc);
    logic [15:0] ir;
    bit done;
    pc = start; acc = '0; cyc = 2; done = 0;
    for (int s = 0; s < 2000 && !done; s++) begin
      ir  = ref_mem[pc];
      pc  = pc + 12'd1;
      cyc += 5;
      case (ir[15:12])
        4'h1: begin acc = ref_mem[ir[11:0]]; cyc += 3; end
        4'h5: begin acc = acc + ref_mem[ir[11:0]]; cyc += 3; end
        4'h2: begin ref_mem[ir[11:0]] = acc; cyc += 1; end
        4'h8: pc = ir[11:0];
        4'h0: done = 1;
        default: ;
      endcase
    end
  endfunction

  task automatic clear_mem();
    for (int i = 0; i < 4096; i++) mem[i] = 16'h0000;
  endtask

  task automatic run_prog(input string name);
    logic [15:0] e_acc;
    logic [11:0] e_pc;
    int          e_cyc;
    int          n;
    int          bad;
    int          first_bad;
    for (int i = 0; i < 4096; i++) ref_mem[i] = mem[i];
    ref_run(12'h300, e_acc, e_pc, e_cyc);
    @(negedge clk);
    rst_n = 1'b1;
    n = 0;
    while (!halted && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(halted == 1'b1, "R7", {name, " stopped"}, halted, 1);
    chk(n == e_cyc, "R10", {name, " edges to stop"}, n, e_cyc);
    chk(acc_value == e_acc, "R3/R5", {name, " accumulator"}, acc_value, e_acc);
    chk(pc_value == e_pc, "R2/R6", {name, " program counter"}, pc_value, e_pc);
    bad = 0; first_bad = 0;
    for (int i = 0; i < 4096; i++) begin
      if (mem[i] !== ref_mem[i]) begin
        if (bad == 0) first_bad = i;
        bad++;
      end
    end
    chk(bad == 0, "R4/R8", {name, " memory image"}, mem[first_bad], ref_mem[first_bad]);
  endtask

  task automatic enter_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [11:0] held_pc;
    logic [15:0] held_acc;
    checks = 0; failures = 0; wr_after_halt = 0;
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    clear_mem();
    repeat (3) @(negedge clk);

    // R1 reset values
    chk(pc_value == 12'h300, "R1", "reset pc", pc_value, 12'h300);
    chk(acc_value == 16'h0, "R1", "reset acc", acc_value, 0);
    chk(halted == 1'b0, "R1", "reset stopped flag", halted, 0);
    chk(mem_we == 1'b0, "R1", "reset write strobe", mem_we, 0);

    // directed: load/add/store example
    mem[12'h300] = 16'h1940;
    mem[12'h301] = 16'h5941;
    mem[12'h302] = 16'h2941;
    mem[12'h303] = 16'h0000;
    mem[12'h940] = 16'h0003;
    mem[12'h941] = 16'h0002;
    run_prog("basic");
    chk(mem[12'h941] == 16'h0005, "R4", "stored sum", mem[12'h941], 16'h0005);

    // R7 stopped core stays put
    held_pc = pc_value; held_acc = acc_value; wr_after_halt = 0;
    repeat (20) @(negedge clk);
    chk(halted == 1'b1, "R7", "stop is sticky", halted, 1);
    chk(pc_value == held_pc, "R7", "pc frozen", pc_value, held_pc);
    chk(acc_value == held_acc, "R7", "acc frozen", acc_value, held_acc);
    chk(wr_after_halt == 0, "R7", "writes after stop", wr_after_halt, 0);

    // R1 asynchronous reset in the middle of a run
    enter_reset();
    @(negedge clk);
    rst_n = 1'b1;
    repeat (12) @(negedge clk);
    chk(acc_value == 16'h0003, "R3", "first load done", acc_value, 16'h0003);
    #1 rst_n = 1'b0;
    #0.5;
    chk(acc_value == 16'h0 && pc_value == 12'h300, "R1", "async reset values",
        {acc_value, 4'h0, pc_value}, {16'h0, 4'h0, 12'h300});
    repeat (2) @(negedge clk);

    // R5 wrap on overflow
    clear_mem();
    mem[12'h300] = 16'h1950;
    mem[12'h301] = 16'h5951;
    mem[12'h302] = 16'h2952;
    mem[12'h303] = 16'h5953;
    mem[12'h304] = 16'h0000;
    mem[12'h950] = 16'h7FFF;
    mem[12'h951] = 16'h0001;
    mem[12'h953] = 16'h8000;
    run_prog("overflow");
    chk(mem[12'h952] == 16'h8000, "R5", "signed overflow sum", mem[12'h952], 16'h8000);
    chk(acc_value == 16'h0000, "R5", "carry dropped", acc_value, 16'h0000);

    // R9 program counter wrap, R6 jump target
    enter_reset();
    clear_mem();
    mem[12'h300] = 16'h8FFF;
    mem[12'hFFF] = 16'h1960;
    mem[12'h000] = 16'h0000;
    mem[12'h960] = 16'h1234;
    run_prog("pc wrap");
    chk(pc_value == 12'h001, "R9", "pc after wrap", pc_value, 12'h001);
    chk(acc_value == 16'h1234, "R6", "jump target executed", acc_value, 16'h1234);

    // R8 unused opcodes are no-ops
    enter_reset();
    clear_mem();
    mem[12'h300] = 16'h1970;
    mem[12'h301] = 16'h3971;
    mem[12'h302] = 16'hF971;
    mem[12'h303] = 16'h7972;
    mem[12'h304] = 16'h0000;
    mem[12'h970] = 16'hABCD;
    mem[12'h971] = 16'h1111;
    mem[12'h972] = 16'h2222;
    run_prog("no-op codes");
    chk(acc_value == 16'hABCD, "R8", "acc untouched", acc_value, 16'hABCD);
    chk(mem[12'h971] == 16'h1111, "R8", "memory untouched", mem[12'h971], 16'h1111);

    // random programs with forward jumps
    for (int p = 0; p < 24; p++) begin
      int len;
      enter_reset();
      clear_mem();
      len = 4 + int'($urandom % 14);
      for (int d = 0; d < 16; d++) mem[12'h900 + d] = 16'($urandom);
      for (int i = 0; i < len - 1; i++) begin
        int kind;
        logic [11:0] daddr;
        logic [3:0]  nop_op;
        kind  = int'($urandom % 10);
        daddr = 12'h900 + 12'($urandom % 16);
        case (kind)
          0, 1, 2: mem[12'h300 + i] = {4'h1, daddr};
          3, 4:    mem[12'h300 + i] = {4'h5, daddr};
          5, 6:    mem[12'h300 + i] = {4'h2, daddr};
          7:       mem[12'h300 + i] = {4'h8,
                     12'h300 + 12'(i + 1 + int'($urandom % (len - 1 - i)))};
          default: begin
            case ($urandom % 6)
              0: nop_op = 4'h3;
              1: nop_op = 4'h4;
              2: nop_op = 4'h6;
              3: nop_op = 4'h9;
              4: nop_op = 4'hC;
              default: nop_op = 4'hF;
            endcase
            mem[12'h300 + i] = {nop_op, daddr};
          end
        endcase
      end
      mem[12'h300 + len - 1] = {4'h0, 12'($urandom)};
      run_prog($sformatf("random%0d", p));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule